// File: doc/BRIEF.md
# Calibrated Seconds Counter

This block keeps a 32-bit count of elapsed seconds. A prescaler outside the block supplies a single-cycle pulse once per second, and each pulse normally advances the count by one. Software may overwrite the count at any time through a load port. The count runs over the full unsigned range and wraps to zero.

Slow drift of the reference clock is corrected one whole second at a time, not by trimming the oscillator. A calibration word holds three fields: an interval length, a direction and an enable. While the enable is set and the direction calls for a correction, an internal interval counter counts seconds pulses. On every (interval+1)-th pulse, the block either adds one extra second or drops that pulse. The calibration word can be read back at any time. Writing it restarts the interval.

Top module: `rtc_sec_cal`

## Requirements
- R1: After reset, `sec_count` is 0 and `cal_rdata` is 0.
- R2: A `tick` with no correction due advances `sec_count` by 1 on the next clock edge. From 0xFFFFFFFF the count wraps to 0.
- R3: When `load_en` is high, `sec_count` takes `load_val` on the next edge. This holds even if `tick` is high in the same cycle.
- R4: A `cal_wr_en` write stores three fields: the interval in bits [18:0], the direction in bits [20:19] and the enable in bit [23]. `cal_rdata` then returns exactly those bits, and bits [22:21] and [31:24] read as 0.
- R5: With enable 1 and direction 3, every (interval+1)-th tick after the last calibration write advances `sec_count` by 2 instead of 1.
- R6: With enable 1 and direction 2, every (interval+1)-th tick after the last calibration write leaves `sec_count` unchanged.
- R7: With direction 0 or 1, every tick advances the count by exactly 1, whatever the enable and interval.
- R8: With enable 0, the direction and interval have no effect, and every tick advances the count by exactly 1.
- R9: A calibration write restarts the interval from zero. The first correction after the write falls on the (interval+1)-th tick counted from that write.
- R10: An inserted second wraps modulo 2^32, so 0xFFFFFFFF advances to 0x00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| load_en | input | 1 | Load `load_val` into the seconds count |
| load_val | input | 32 | Value to load |
| cal_wr_en | input | 1 | Write the calibration word |
| cal_wr_data | input | 32 | Calibration word to write |
| sec_count | output | 32 | Current seconds count |
| cal_rdata | output | 32 | Calibration word readback |

## Verification
The bench sweeps all four direction codes, both enable values and intervals 0 to 4. For each combination it loads a known count and sends a fixed burst of twelve ticks. The final count shows whether a correction happened, which way it went, and whether it fell on every (interval+1)-th tick; an off-by-one in the interval compare or a swapped direction gives a different total. Separate patterns check a restart in mid-interval, a load colliding with a tick, reserved-bit masking in the readback, and wrap at the top of the range for both plain and inserted seconds.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int MATCH_W   = 19;
  localparam int CTRL_LSB  = 19;
  localparam int VALID_BIT = 23;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    DIR_NONE0 = 2'd0,
    DIR_NONE1 = 2'd1,
    DIR_DROP  = 2'd2,
    DIR_ADD   = 2'd3
  } dir_e;

  typedef struct packed {
    logic               en;
    dir_e               dir;
    logic [MATCH_W-1:0] span;
  } cal_t;
endpackage

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output cal_t              cal_q,
  output logic [WORD_W-1:0] rd_data
);
  cal_t cal_d;

  always_comb begin
    cal_d = cal_q;
    if (wr_en) begin
      cal_d.span = wr_data[MATCH_W-1:0];
      cal_d.dir  = dir_e'(wr_data[CTRL_LSB+1:CTRL_LSB]);
      cal_d.en   = wr_data[VALID_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cal_q <= '0;
    else if (wr_en) cal_q <= cal_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[MATCH_W-1:0]         = cal_q.span;
    rd_data[CTRL_LSB+1:CTRL_LSB] = cal_q.dir;
    rd_data[VALID_BIT]           = cal_q.en;
  end
endmodule

// File: rtl/rtc_period_ctr.sv
module rtc_period_ctr
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               restart,
  input  logic               active,
  input  logic [MATCH_W-1:0] span,
  output logic               fire
);
  logic [MATCH_W-1:0] cnt_q, cnt_d;
  logic               at_end;

  assign at_end = (cnt_q == span);
  assign fire   = tick && active && !restart && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !active) cnt_d = '0;
    else if (tick)          cnt_d = at_end ? '0 : cnt_q + MATCH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_sec_ctr.sv
module rtc_sec_ctr #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_val,
  input  logic             do_add,
  input  logic             do_drop,
  output logic [SEC_W-1:0] sec_q
);
  logic [SEC_W-1:0] sec_d;
  logic             upd;

  always_comb begin
    sec_d = sec_q;
    if (load_en)      sec_d = load_val;
    else if (tick) begin
      if (do_add)       sec_d = sec_q + SEC_W'(2);
      else if (do_drop) sec_d = sec_q;
      else              sec_d = sec_q + SEC_W'(1);
    end
  end

  assign upd = load_en || tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sec_q <= '0;
    else if (upd) sec_q <= sec_d;
  end
endmodule

// File: rtl/rtc_sec_cal.sv
module rtc_sec_cal
  import rtc_cal_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_en,
  input  logic [SEC_W-1:0]  load_val,
  input  logic              cal_wr_en,
  input  logic [WORD_W-1:0] cal_wr_data,
  output logic [SEC_W-1:0]  sec_count,
  output logic [WORD_W-1:0] cal_rdata
);
  cal_t cal;
  logic corr_active, fire, do_add, do_drop;

  rtc_cal_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cal_wr_en), .wr_data(cal_wr_data),
    .cal_q(cal), .rd_data(cal_rdata)
  );

  assign corr_active = cal.en && (cal.dir == DIR_ADD || cal.dir == DIR_DROP);

  rtc_period_ctr u_period (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(cal_wr_en),
    .active(corr_active), .span(cal.span), .fire(fire)
  );

  assign do_add  = fire && (cal.dir == DIR_ADD);
  assign do_drop = fire && (cal.dir == DIR_DROP);

  rtc_sec_ctr #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
    .load_val(load_val), .do_add(do_add), .do_drop(do_drop), .sec_q(sec_count)
  );
endmodule

// File: rtl/rtc_sec_cal_chk.sv
module rtc_sec_cal_chk #(
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             load_en,
  input logic [SEC_W-1:0] load_val,
  input logic             cal_wr_en,
  input logic [31:0]      cal_wr_data,
  input logic [SEC_W-1:0] sec_count,
  input logic [31:0]      cal_rdata
);
  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> sec_count == $past(load_val));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_en) |=> $stable(sec_count));
  // R4
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_rdata[31:24] == 8'h0 && cal_rdata[22:21] == 2'b00);
  // R4
  cal_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr_en |=> cal_rdata == ($past(cal_wr_data) & 32'h009F_FFFF));
  // R8
  no_en_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en && !cal_wr_en && !cal_rdata[23]) |=>
      sec_count == $past(sec_count) + SEC_W'(1));
  // R7
  no_dir_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en && !cal_wr_en && !cal_rdata[20]) |=>
      sec_count == $past(sec_count) + SEC_W'(1));
  // R5
  add_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en && cal_rdata[23] && cal_rdata[20:19] == 2'd3) |=>
      (sec_count == $past(sec_count) + SEC_W'(1) ||
       sec_count == $past(sec_count) + SEC_W'(2)));
  // R6
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en && !cal_wr_en && cal_rdata[23] && cal_rdata[20:19] == 2'd2) |=>
      (sec_count == $past(sec_count) + SEC_W'(1) ||
       sec_count == $past(sec_count)));
endmodule

bind rtc_sec_cal rtc_sec_cal_chk #(.SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
  .load_val(load_val), .cal_wr_en(cal_wr_en), .cal_wr_data(cal_wr_data),
  .sec_count(sec_count), .cal_rdata(cal_rdata)
);

// File: tb/rtc_sec_cal_bench.sv
module rtc_sec_cal_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_val = '0;
  logic        cal_wr_en = 1'b0;
  logic [31:0] cal_wr_data = '0;
  logic [31:0] sec_count, cal_rdata;
  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_sec_cal u_rtc_sec_cal (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
    .load_val(load_val), .cal_wr_en(cal_wr_en), .cal_wr_data(cal_wr_data),
    .sec_count(sec_count), .cal_rdata(cal_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask
  task automatic do_load(logic [31:0] v);
    load_en = 1'b1; load_val = v; @(negedge clk); load_en = 1'b0;
  endtask
  task automatic do_cal(logic [31:0] w);
    cal_wr_en = 1'b1; cal_wr_data = w; @(negedge clk); cal_wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sec", sec_count, 32'h0);
    check("R1 cal", cal_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    do_tick();
    check("R2 step", sec_count, 32'h1);
    do_load(32'hFFFF_FFFF);
    check("R3 load", sec_count, 32'hFFFF_FFFF);
    do_tick();
    check("R2 wrap", sec_count, 32'h0);

    load_en = 1'b1; load_val = 32'h1234_5678; tick = 1'b1;
    @(negedge clk);
    load_en = 1'b0; tick = 1'b0;
    check("R3 load over tick", sec_count, 32'h1234_5678);

    do_cal(32'hFFFF_FFFF);
    check("R4 mask", cal_rdata, 32'h009F_FFFF);

    // Sweep: direction 0..3, enable 0/1, interval 0..4, 12 ticks each
    for (int dir = 0; dir < 4; dir++)
      for (int en = 0; en < 2; en++)
        for (int m = 0; m < 5; m++) begin
          logic [31:0] w, exp;
          int nc;
          string tag;
          w = (32'(en) << 23) | (32'(dir) << 19) | 32'(m);
          do_cal(w);
          check("R4 readback", cal_rdata, w);
          do_load(32'd100);
          for (int k = 0; k < 12; k++) do_tick();
          nc = (en == 1 && dir >= 2) ? 12 / (m + 1) : 0;
          if (en == 0)       tag = "R8 disabled";
          else if (dir < 2)  tag = "R7 no dir";
          else if (dir == 3) tag = "R5 insert";
          else               tag = "R6 swallow";
          exp = (dir == 3) ? 32'(100 + 12 + nc) : 32'(100 + 12 - nc);
          check(tag, sec_count, exp);
        end

    // R9: restart mid-interval, interval 3, insert
    do_cal((32'd1 << 23) | (32'd3 << 19) | 32'd3);
    do_load(32'd0);
    do_tick(); do_tick();
    do_cal((32'd1 << 23) | (32'd3 << 19) | 32'd3);
    check("R9 before", sec_count, 32'd2);
    do_tick(); do_tick(); do_tick();
    check("R9 no early corr", sec_count, 32'd5);
    do_tick();
    check("R9 corr on 4th", sec_count, 32'd7);

    // R10: insert wraps
    do_cal((32'd1 << 23) | (32'd3 << 19));
    do_load(32'hFFFF_FFFF);
    do_tick();
    check("R10 insert wrap", sec_count, 32'h1);

    // R6 boundary: swallow every tick holds
    do_cal((32'd1 << 23) | (32'd2 << 19));
    do_load(32'h8000_0000);
    do_tick(); do_tick();
    check("R6 hold", sec_count, 32'h8000_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule